// File: doc/BRIEF.md
# FRC Colour Dithering Engine

This block takes a 24-bit RGB pixel stream, 8 bits per channel, and produces pixels for a panel that shows only 6 bits per channel. It uses frame rate control to do this. First each channel is widened to 9 bits. The top 6 bits are kept. The 3 bits below them form a code from 0 to 7. That code is compared with a rank, which depends on the frame, line and pixel position and differs between green and red/blue. Where the rank is below the code, the kept value is raised by one. Over space and time this averages the lost precision back in.

The engine counts three phases. The pixel phase counts within an active line. The line phase counts active lines. The frame phase advances modulo 4. These phases come from the display timing inputs. Frame and line boundaries can come either from the HS and VS edges or from data-enable alone, where a long DE-inactive gap marks a new frame. The active level of each timing input is programmable.

Each pixel is classified first, and one of four algorithms is chosen. The special algorithms suppress or reshape the dither around black/white pixels and around subpixels at full scale or zero. Two copies can be placed around a white-balance stage. Each copy passes its input through unchanged when it is disabled.

Top module: `frc_dither`

## Requirements
- R1: A channel value v is widened to 9 bits as {v, v[7]}. The kept value is u = v[7:2]. The code is c = {v[1:0], v[7]}.
- R2: When enabled, each output byte is {u + inc, 2'b00}, with inc in {0,1}. It appears one clock after the input. The increment is suppressed when u = 63, so the value never wraps. Reset clears all outputs.
- R3: inc = 1 exactly when the algorithm is not BW and rank < c. For green the base rank is {p[1]^p[2]^l[1], p[0], l[0]}. For red and blue it is {p[1]^l[1], p[0], ~l[0]}. Here p is the 3-bit pixel phase and l is the 2-bit line phase. In the default algorithm the rank is XORed with {f, 1'b0}, where f is the 2-bit frame phase.
- R4: With c = 1 and frame phase 0, green is raised only at line 0, pixels 0 and 6, and at line 2, pixels 2 and 4. Red and blue are raised only at line 1, pixels 0 and 4, and at line 3, pixels 2 and 6.
- R5: Within any one frame of 4 lines by 8 pixels, a channel with code c is raised in exactly 4·c of the 32 cells.
- R6: The pixel phase is 0 on the first active pixel of a line and counts up modulo 8. The line phase is zeroed by a frame event and advances once per active line. The frame phase advances by 1 modulo 4 on every frame event. All three start at 0 after reset.
- R7: When sync_mode = 0, a frame event occurs on the cycle that completes IDLE_FRAME consecutive DE-inactive cycles, and the line phase advances on each DE deactivation. A shorter gap causes no frame event.
- R8: When sync_mode = 1, a frame event occurs on each VS activation. The line phase advances on an HS activation only after an active line since the last advance or frame event. A polarity input of 1 means active-high and 0 means active-low, for its signal.
- R9: Algorithm BW (highest priority) applies when the previous cycle carried an active pixel with all three channels at 0x00, or all three at 0xFF. It adds no increment to any channel.
- R10: Otherwise, if any channel is 0xFF, the engine uses algorithm ON: the frame phase is treated as 0.
- R11: Otherwise, if any channel is 0x00, the engine uses algorithm OFF: the frame phase is treated as 0 and the pixel phase is replaced by its bitwise inverse. In all other cases the default algorithm applies.
- R12: When en = 0, each output byte equals the input byte from the previous clock.
- R13: out_hs, out_vs and out_de equal the raw in_hs, in_vs and in_de from the previous clock, whatever the mode or enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | 1 = dither, 0 = bypass |
| sync_mode | input | 1 | 1 = HS/VS timing, 0 = DE-only timing |
| hs_pol | input | 1 | HS active level |
| vs_pol | input | 1 | VS active level |
| de_pol | input | 1 | DE active level |
| in_r | input | 8 | Red input |
| in_g | input | 8 | Green input |
| in_b | input | 8 | Blue input |
| in_hs | input | 1 | Horizontal sync |
| in_vs | input | 1 | Vertical sync |
| in_de | input | 1 | Data enable |
| out_r | output | 8 | Red output, 6 significant bits when enabled |
| out_g | output | 8 | Green output |
| out_b | output | 8 | Blue output |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |
| out_de | output | 1 | Delayed data enable |

## Verification
A wrong pixel, line or frame phase does not break the output format. It moves the increment cells, so each wrong increment shows up on the very next output pixel, one clock after the input. A mismatch appears as soon as a nonzero code falls on a moved cell. Sweeping every value over every cell and frame phase makes sure such a fault is seen within a few frames. A lost or spurious frame event shifts the temporal pattern of all later frames. A stale previous-pixel flag shows up on the first pixel after a black or white one.

// File: rtl/frc_dither.sv
module frc_dither #(
  parameter int IDLE_FRAME = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       sync_mode,
  input  logic       hs_pol,
  input  logic       vs_pol,
  input  logic       de_pol,
  input  logic [7:0] in_r,
  input  logic [7:0] in_g,
  input  logic [7:0] in_b,
  input  logic       in_hs,
  input  logic       in_vs,
  input  logic       in_de,
  output logic [7:0] out_r,
  output logic [7:0] out_g,
  output logic [7:0] out_b,
  output logic       out_hs,
  output logic       out_vs,
  output logic       out_de
);
  localparam int IW = $clog2(IDLE_FRAME + 1);
  localparam logic [1:0] ALG_DEF = 2'd0, ALG_BW = 2'd1, ALG_ON = 2'd2, ALG_OFF = 2'd3;

  logic hs_a, vs_a, de_a, hs_q, vs_q, de_q, seen, prev_bw;
  logic frame_evt, line_evt, cur_bw, any_ff, any_00;
  logic [2:0] pix, p_eff;
  logic [1:0] line, frame, f_eff, alg;
  logic [IW-1:0] idle;
  logic [7:0] chv [3];
  logic [7:0] dith [3];

  assign hs_a = in_hs ~^ hs_pol;
  assign vs_a = in_vs ~^ vs_pol;
  assign de_a = in_de ~^ de_pol;

  assign frame_evt = sync_mode ? (vs_a & ~vs_q) : (~de_a && idle == IW'(IDLE_FRAME - 1));
  assign line_evt  = sync_mode ? (hs_a & ~hs_q & seen) : (de_q & ~de_a);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q <= 1'b0; vs_q <= 1'b0; de_q <= 1'b0; seen <= 1'b0; prev_bw <= 1'b0;
      pix <= '0; line <= '0; frame <= '0; idle <= '0;
    end else begin
      hs_q <= hs_a; vs_q <= vs_a; de_q <= de_a;
      pix <= de_a ? pix + 3'd1 : 3'd0;
      idle <= de_a ? '0 : (idle == IW'(IDLE_FRAME) ? idle : idle + IW'(1));
      prev_bw <= de_a & cur_bw;
      if (frame_evt) begin
        frame <= frame + 2'd1; line <= '0; seen <= 1'b0;
      end else if (line_evt) begin
        line <= line + 2'd1; seen <= 1'b0;
      end else if (de_a) begin
        seen <= 1'b1;
      end
    end
  end

  assign chv[0] = in_r;
  assign chv[1] = in_g;
  assign chv[2] = in_b;

  assign cur_bw = ({in_r, in_g, in_b} == 24'h0) || ({in_r, in_g, in_b} == 24'hFFFFFF);
  assign any_ff = (in_r == 8'hFF) || (in_g == 8'hFF) || (in_b == 8'hFF);
  assign any_00 = (in_r == 8'h00) || (in_g == 8'h00) || (in_b == 8'h00);

  always_comb begin
    if (prev_bw)     alg = ALG_BW;
    else if (any_ff) alg = ALG_ON;
    else if (any_00) alg = ALG_OFF;
    else             alg = ALG_DEF;
  end

  assign f_eff = (alg == ALG_DEF) ? frame : 2'd0;
  assign p_eff = (alg == ALG_OFF) ? ~pix : pix;

  for (genvar ch = 0; ch < 3; ch++) begin : g_ch
    logic [5:0] up;
    logic [2:0] code, rank, rk;
    logic inc;
    assign up   = chv[ch][7:2];
    assign code = {chv[ch][1:0], chv[ch][7]};
    if (ch == 1) begin : g_green
      assign rank = {p_eff[1] ^ p_eff[2] ^ line[1], p_eff[0], line[0]};
    end else begin : g_redblue
      assign rank = {p_eff[1] ^ line[1], p_eff[0], ~line[0]};
    end
    assign rk  = rank ^ {f_eff, 1'b0};
    assign inc = (alg != ALG_BW) && (rk < code) && (up != 6'h3F);
    assign dith[ch] = {up + {5'd0, inc}, 2'b00};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_r <= '0; out_g <= '0; out_b <= '0;
      out_hs <= 1'b0; out_vs <= 1'b0; out_de <= 1'b0;
    end else begin
      out_r <= en ? dith[0] : in_r;
      out_g <= en ? dith[1] : in_g;
      out_b <= en ? dith[2] : in_b;
      out_hs <= in_hs; out_vs <= in_vs; out_de <= in_de;
    end
  end
endmodule

// File: rtl/frc_dither_chk.sv
module frc_dither_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [7:0] in_r,
  input logic [7:0] in_g,
  input logic [7:0] in_b,
  input logic       in_hs,
  input logic       in_vs,
  input logic       in_de,
  input logic [7:0] out_r,
  input logic [7:0] out_g,
  input logic [7:0] out_b,
  input logic       out_hs,
  input logic       out_vs,
  input logic       out_de
);
  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  assert_bypass_R12: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(en) |-> {out_r, out_g, out_b} == $past({in_r, in_g, in_b}));

  assert_sync_delay_R13: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    {out_hs, out_vs, out_de} == $past({in_hs, in_vs, in_de}));

  assert_red_step_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(en) |-> out_r[1:0] == 2'b00 &&
      (out_r[7:2] == $past(in_r[7:2]) || out_r[7:2] == $past(in_r[7:2]) + 6'd1));

  assert_green_step_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(en) |-> out_g[1:0] == 2'b00 &&
      (out_g[7:2] == $past(in_g[7:2]) || out_g[7:2] == $past(in_g[7:2]) + 6'd1));

  assert_blue_step_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(en) |-> out_b[1:0] == 2'b00 &&
      (out_b[7:2] == $past(in_b[7:2]) || out_b[7:2] == $past(in_b[7:2]) + 6'd1));

  assert_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(en) && $past(in_g[7:2]) == 6'h3F |-> out_g[7:2] == 6'h3F);

  assert_zero_code_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(en) && $past(in_r) == 8'h00 |-> out_r == 8'h00);
endmodule

bind frc_dither frc_dither_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en(en),
  .in_r(in_r), .in_g(in_g), .in_b(in_b),
  .in_hs(in_hs), .in_vs(in_vs), .in_de(in_de),
  .out_r(out_r), .out_g(out_g), .out_b(out_b),
  .out_hs(out_hs), .out_vs(out_vs), .out_de(out_de)
);

// File: tb/frc_dither_tb.sv
module frc_dither_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int THR = 12;

  logic clk = 1'b0;
  logic rst_n, en, sync_mode, hs_pol, vs_pol, de_pol;
  logic [7:0] in_r, in_g, in_b;
  logic in_hs, in_vs, in_de;
  logic [7:0] out_r, out_g, out_b;
  logic out_hs, out_vs, out_de;

  int vecs = 0, errs = 0, fph = 0;
  bit pbw = 1'b0;
  int inc_cnt [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  frc_dither #(.IDLE_FRAME(THR)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .sync_mode(sync_mode),
    .hs_pol(hs_pol), .vs_pol(vs_pol), .de_pol(de_pol),
    .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .in_hs(in_hs), .in_vs(in_vs), .in_de(in_de),
    .out_r(out_r), .out_g(out_g), .out_b(out_b),
    .out_hs(out_hs), .out_vs(out_vs), .out_de(out_de));

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit is_bw(input logic [23:0] d);
    return d == 24'h0 || d == 24'hFFFFFF;
  endfunction

  // Reference from R1, R3, R9-R11
  function automatic logic [23:0] model(input logic [23:0] d, input bit prev, input int f, input int l, input int p);
    logic [7:0] v [3];
    logic [23:0] res;
    logic [2:0] pe, rank, code;
    logic [1:0] lv, fe;
    logic [5:0] up;
    int alg;
    v[0] = d[23:16]; v[1] = d[15:8]; v[2] = d[7:0];
    if (prev) alg = 1;
    else if (v[0] == 8'hFF || v[1] == 8'hFF || v[2] == 8'hFF) alg = 2;
    else if (v[0] == 8'h00 || v[1] == 8'h00 || v[2] == 8'h00) alg = 3;
    else alg = 0;
    pe = 3'(p); lv = 2'(l); fe = 2'(f);
    if (alg != 0) fe = 2'd0;
    if (alg == 3) pe = ~pe;
    res = '0;
    for (int ch = 0; ch < 3; ch++) begin
      up = v[ch][7:2];
      code = {v[ch][1:0], v[ch][7]};
      if (ch == 1) rank = {pe[1] ^ pe[2] ^ lv[1], pe[0], lv[0]};
      else         rank = {pe[1] ^ lv[1], pe[0], ~lv[0]};
      rank = rank ^ {fe, 1'b0};
      if (alg != 1 && rank < code && up != 6'h3F) up = up + 6'd1;
      res[23 - 8*ch -: 8] = {up, 2'b00};
    end
    return res;
  endfunction

  task automatic cyc(input logic [23:0] d, input bit hs_a, input bit vs_a, input bit de_a,
                     input int l, input int p, input string req);
    logic [23:0] e;
    logic [2:0] raw;
    {in_r, in_g, in_b} = d;
    in_hs = hs_a ? hs_pol : ~hs_pol;
    in_vs = vs_a ? vs_pol : ~vs_pol;
    in_de = de_a ? de_pol : ~de_pol;
    raw = {in_hs, in_vs, in_de};
    e = !en ? d : model(d, pbw, fph, l, de_a ? p : 0);
    @(posedge clk); #2;
    chk({out_hs, out_vs, out_de} == raw, "R13", {21'd0, out_hs, out_vs, out_de}, {21'd0, raw});
    chk({out_r, out_g, out_b} == e, req, {out_r, out_g, out_b}, e);
    if (en && de_a) begin
      inc_cnt[0] += int'(out_r[7:2]) - int'(d[23:18]);
      inc_cnt[1] += int'(out_g[7:2]) - int'(d[15:10]);
      inc_cnt[2] += int'(out_b[7:2]) - int'(d[7:2]);
    end
    pbw = de_a && is_bw(d);
  endtask

  function automatic logic [23:0] pix_val(input int kind, input int n, input int l, input int p);
    logic [7:0] v, c;
    logic [2:0] k;
    case (kind)
      0: begin v = 8'((n >> 2) + l*8 + p); return {v, v ^ 8'h5A, ~v}; end
      1: begin
        c = 8'(n*37 + l*11 + p*3 + 5);
        case (p)
          0: return 24'h000000;
          1: return {c, c + 8'd1, c + 8'd2};
          2: return 24'hFFFFFF;
          3: return {c, 8'hFF, c};
          4: return {c, 8'hFF, c ^ 8'h10};
          5: return {8'h00, c, c + 8'd3};
          6: return {c, 8'h00, 8'hFF};
          default: return {c, c ^ 8'h24, c ^ 8'h42};
        endcase
      end
      2: begin k = 3'(n); v = {k[0], 5'b10000, k[2:1]}; return {v, v, v}; end
      default: return 24'h808080;
    endcase
  endfunction

  // lead: DE-only leading gap (plus 3 pre-line blanks); sync mode uses VS
  task automatic run_frame(input int kind, input int n, input int lead, input string req);
    bit g_inc, rb_inc;
    logic [23:0] e;
    if (sync_mode) begin
      repeat (2) cyc(24'h0, 0, 1, 0, 0, 0, "R8");
      fph = (fph + 1) % 4;
    end else begin
      repeat (lead) cyc(24'h0, 0, 0, 0, 0, 0, "R7");
      if (lead + 3 >= THR) fph = (fph + 1) % 4;
    end
    for (int l = 0; l < 4; l++) begin
      if (sync_mode) cyc(24'h0, 1, 0, 0, l, 0, "R8");
      repeat (sync_mode ? 2 : 3) cyc(24'h0, 0, 0, 0, l, 0, "R6");
      for (int p = 0; p < 8; p++) begin
        cyc(pix_val(kind, n, l, p), 0, 0, 1, l, p, req);
        if (kind == 3 && fph == 0 && en) begin
          // R4: literal cell list for code 1 at frame phase 0
          g_inc  = (l == 0 && (p == 0 || p == 6)) || (l == 2 && (p == 2 || p == 4));
          rb_inc = (l == 1 && (p == 0 || p == 4)) || (l == 3 && (p == 2 || p == 6));
          e = {rb_inc ? 8'h84 : 8'h80, g_inc ? 8'h84 : 8'h80, rb_inc ? 8'h84 : 8'h80};
          chk({out_r, out_g, out_b} == e, "R4", {out_r, out_g, out_b}, e);
        end
      end
      if (sync_mode) repeat (2) cyc(24'h0, 0, 0, 0, l, 0, "R6");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errs++;
    $display("FAIL watchdog actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; sync_mode = 1'b1;
    hs_pol = 1'b1; vs_pol = 1'b1; de_pol = 1'b1;
    {in_r, in_g, in_b} = 24'h123456; in_hs = 1'b0; in_vs = 1'b0; in_de = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk({out_r, out_g, out_b, out_hs, out_vs, out_de} == 27'd0, "R2 reset",
        {out_r, out_g, out_b}, 24'h0);
    @(negedge clk);
    rst_n = 1'b1;

    en = 1'b0;
    for (int n = 0; n < 2; n++) run_frame(0, n * 37, 0, "R12");
    en = 1'b1;

    for (int n = 0; n < 1024; n++) run_frame(0, n, 0, "R3");

    hs_pol = 1'b0; de_pol = 1'b0;
    for (int n = 0; n < 16; n++) run_frame(1, n, 0, "R9 R10 R11");
    hs_pol = 1'b1; de_pol = 1'b1;

    for (int k = 0; k < 8; k++) begin
      for (int ch = 0; ch < 3; ch++) inc_cnt[ch] = 0;
      run_frame(2, k, 0, "R5");
      for (int ch = 0; ch < 3; ch++)
        chk(inc_cnt[ch] == 4 * k, "R5 count", 24'(inc_cnt[ch]), 24'(4 * k));
    end
    for (int n = 0; n < 4; n++) run_frame(3, 0, 0, "R4");

    sync_mode = 1'b0; hs_pol = 1'b0; vs_pol = 1'b0; de_pol = 1'b0;
    for (int n = 0; n < 12; n++) run_frame(0, 400 + n * 13, (n % 3 == 2) ? THR - 4 : THR + 2, "R7 R8");
    de_pol = 1'b1;
    for (int n = 0; n < 6; n++) run_frame(1, n, (n % 2) ? THR - 3 : THR - 4, "R7");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule